// File: doc/BRIEF.md
# Serial Programming Target Shift Interface

This block is the target side of a four-byte serial programming link. It watches a serial clock, a host-to-target data line and a programming-window input, all sampled in the system clock domain. Within a programming window it shifts host bits into bytes and groups every four bytes into one 32-bit instruction frame. Completed frames are sorted into enable, load, write and read commands and passed to a memory back end as one-cycle pulses. On the target-to-host line it returns the byte received just before the current one. A read returns memory data in its final byte.

No command is accepted until a programming-enable frame (first byte 0xAC, second byte 0x53) has been seen. The host can tell it is aligned because the 0x53 comes back while it sends the third byte. A frame ends only after 32 bits, so a host that clocks all four bytes every time stays aligned even when the echo is wrong. Closing the programming window clears the bit and byte counters and the enable state. A short pulse on that input therefore restores frame alignment.

Top module: `sprog_target`

## Requirements
- R1: After system reset, and for as long as `hold_i` is low, `miso_o` is 0, `cmd_valid_o` and `rd_req_o` stay low, and the enable state is clear.
- R2: `mosi_i` is sampled on each rising edge of `sck_i`, most significant bit first. After the 32nd rising edge, `cmd_frame_o` holds the four received bytes with the first byte in bits 31:24.
- R3: `miso_o` changes only after a falling edge of `sck_i` or when `hold_i` drops, so it is stable while `sck_i` is high.
- R4: While the third byte of any frame is being clocked, `miso_o` carries the second byte of that frame. For an enable frame this is 0x53.
- R5: A frame whose first byte is 0xAC and second byte is 0x53 sets the enable state and pulses `cmd_valid_o` with `cmd_kind_o` = 1 (enable).
- R6: While the enable state is clear, every frame that is not an enable frame gives no `cmd_valid_o` or `rd_req_o` pulse. Its fourth byte echoes its third byte.
- R7: Once enabled, the top three bits of the first byte select the kind: 001 gives read (kind 4), 010 gives load (kind 2), 110 gives write (kind 3). Every other pattern gives no pulse. Kind 0 is never output.
- R8: For an enabled read frame, `rd_req_o` pulses once after the third byte, with `rd_addr_o` = {second byte, third byte}. During the fourth byte `miso_o` shifts out `rd_data_i`, MSB first.
- R9: A frame is complete after exactly 32 bits whether or not its echo matched. An enable frame with a wrong second byte is not accepted, and the frame that follows it is still aligned.
- R10: Dropping `hold_i` discards any partial frame, clears the enable state and restarts bit and byte counting at the next window.
- R11: While the first byte of a frame is being clocked, `miso_o` is 0. During the second byte it carries the first byte. During the fourth byte of a non-read frame it carries the third byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| hold_i | input | 1 | High while the programming window is open |
| sck_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| cmd_valid_o | output | 1 | One-cycle pulse for a decoded command |
| cmd_kind_o | output | 3 | Command kind: 1 enable, 2 load, 3 write, 4 read |
| cmd_frame_o | output | 32 | Complete received frame |
| rd_req_o | output | 1 | One-cycle read request after byte three |
| rd_addr_o | output | 16 | Read address: bytes two and three |
| rd_data_i | input | 8 | Read data, sampled at the next falling serial clock edge |

## Verification
The assertions assume that `sck_i` and `mosi_i` change slowly compared with `clk`, so that each level lasts longer than the synchronizer delay plus one cycle. They also assume `mosi_i` is stable around each rising serial clock edge and `rd_data_i` is stable from the read request until the following falling edge. The stimulus holds every serial clock phase for ten system clocks. It changes the data line only while the serial clock is low. It drives the read data as a fixed function of the registered read address, which changes only with the read request.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

   typedef enum logic [2:0] {
      CMD_NONE   = 3'd0,
      CMD_ENABLE = 3'd1,
      CMD_LOAD   = 3'd2,
      CMD_WRITE  = 3'd3,
      CMD_READ   = 3'd4
   } cmd_kind_e;

   typedef enum logic [1:0] {
      TX_ZERO  = 2'd0,
      TX_ECHO  = 2'd1,
      TX_RDATA = 2'd2
   } tx_sel_e;

   localparam logic [2:0] OPC_READ  = 3'b001;
   localparam logic [2:0] OPC_LOAD  = 3'b010;
   localparam logic [2:0] OPC_WRITE = 3'b110;

   function automatic cmd_kind_e kind_of(input logic [2:0] opc);
      case (opc)
         OPC_READ:  return CMD_READ;
         OPC_LOAD:  return CMD_LOAD;
         OPC_WRITE: return CMD_WRITE;
         default:   return CMD_NONE;
      endcase
   endfunction

endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("sprog_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else if (STAGES == 1) chain <= d;
         else chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/sprog_rx.sv
module sprog_rx #(
   parameter int BYTE_W      = 8,
   parameter int FRAME_BYTES = 4,
   localparam int FRAME_W    = BYTE_W * FRAME_BYTES,
   localparam int BIT_W      = (BYTE_W > 1) ? $clog2(BYTE_W) : 1,
   localparam int IDX_W      = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               rise,
   input  logic               mosi,
   output logic [FRAME_W-1:0] sh_o,
   output logic               byte_done_o,
   output logic [IDX_W-1:0]   byte_idx_o,
   output logic               frame_done_o
);
   logic [BIT_W-1:0] bit_cnt;
   logic [IDX_W-1:0] byte_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_o         <= '0;
         bit_cnt      <= '0;
         byte_cnt     <= '0;
         byte_done_o  <= 1'b0;
         byte_idx_o   <= '0;
         frame_done_o <= 1'b0;
      end else if (clr) begin
         sh_o         <= '0;
         bit_cnt      <= '0;
         byte_cnt     <= '0;
         byte_done_o  <= 1'b0;
         byte_idx_o   <= '0;
         frame_done_o <= 1'b0;
      end else begin
         byte_done_o  <= 1'b0;
         frame_done_o <= 1'b0;
         if (rise) begin
            sh_o <= {sh_o[FRAME_W-2:0], mosi};
            if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
               bit_cnt     <= '0;
               byte_done_o <= 1'b1;
               byte_idx_o  <= byte_cnt;
               if (byte_cnt == IDX_W'(FRAME_BYTES - 1)) begin
                  byte_cnt     <= '0;
                  frame_done_o <= 1'b1;
               end else begin
                  byte_cnt <= byte_cnt + 1'b1;
               end
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   // R9: a frame closes only on the last bit of the last byte
   p_frame_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> (byte_done_o && byte_idx_o == IDX_W'(FRAME_BYTES - 1)));

   // R10: closing the window restarts counting
   p_clear_counts_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (bit_cnt == '0 && byte_cnt == '0 && !frame_done_o));

   // R2: one bit per rising edge, never two byte completions back to back
   p_byte_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done_o |=> !byte_done_o);
endmodule

// File: rtl/sprog_tx.sv
module sprog_tx #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fall,
   input  logic              load_req,
   input  logic [BYTE_W-1:0] load_val,
   output logic              miso_o
);
   logic [BYTE_W-1:0] tx;
   logic              pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx   <= '0;
         pend <= 1'b0;
      end else if (clr) begin
         tx   <= '0;
         pend <= 1'b0;
      end else begin
         if (load_req) pend <= 1'b1;
         if (fall) begin
            if (pend) begin
               tx   <= load_val;
               pend <= load_req;
            end else begin
               tx <= {tx[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso_o = tx[BYTE_W-1];

   // R3: the output line moves only on a falling serial edge or a window close
   p_miso_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall && !clr) |=> $stable(miso_o));

   // R1: a closed window leaves the line low
   p_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !miso_o);
endmodule

// File: rtl/sprog_target.sv
module sprog_target
   import sprog_pkg::*;
#(
   parameter int          BYTE_W      = 8,
   parameter int          FRAME_BYTES = 4,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  EN_OP0      = 8'hAC,
   parameter logic [7:0]  EN_OP1      = 8'h53,
   localparam int         FRAME_W     = BYTE_W * FRAME_BYTES,
   localparam int         ADDR_W      = BYTE_W * (FRAME_BYTES - 2),
   localparam int         IDX_W       = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold_i,
   input  logic               sck_i,
   input  logic               mosi_i,
   output logic               miso_o,
   output logic               cmd_valid_o,
   output logic [2:0]         cmd_kind_o,
   output logic [FRAME_W-1:0] cmd_frame_o,
   output logic               rd_req_o,
   output logic [ADDR_W-1:0]  rd_addr_o,
   input  logic [BYTE_W-1:0]  rd_data_i
);
   if (FRAME_BYTES < 3) begin : g_bad_frame
      $error("sprog_target: FRAME_BYTES must be at least 3");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("sprog_target: enable opcodes assume BYTE_W of 8");
   end

   logic sck_s, mosi_s, sck_d, rise, fall, clr;

   sprog_sync #(.STAGES(SYNC_STAGES)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
   sprog_sync #(.STAGES(SYNC_STAGES)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(mosi_i), .q(mosi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign rise = sck_s & ~sck_d;
   assign fall = ~sck_s & sck_d;
   assign clr  = ~hold_i;

   logic [FRAME_W-1:0] sh;
   logic               byte_done, frame_done;
   logic [IDX_W-1:0]   byte_idx;

   sprog_rx #(.BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rise(rise), .mosi(mosi_s),
      .sh_o(sh), .byte_done_o(byte_done), .byte_idx_o(byte_idx),
      .frame_done_o(frame_done));

   // frame decode
   logic [BYTE_W-1:0] b0, b1;
   cmd_kind_e         kind;
   logic              en_q;

   assign b0 = sh[FRAME_W-1 -: BYTE_W];
   assign b1 = sh[FRAME_W-BYTE_W-1 -: BYTE_W];

   always_comb begin
      if (b0 == EN_OP0 && b1 == EN_OP1) kind = CMD_ENABLE;
      else if (en_q)                     kind = kind_of(b0[BYTE_W-1 -: 3]);
      else                               kind = CMD_NONE;
   end

   // read opcode seen after the byte before last
   logic [2:0] mid_opc;
   assign mid_opc = sh[(FRAME_BYTES-1)*BYTE_W-1 -: 3];

   tx_sel_e           sel_q;
   logic [BYTE_W-1:0] echo_q;
   logic [BYTE_W-1:0] load_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q        <= 1'b0;
         cmd_valid_o <= 1'b0;
         cmd_kind_o  <= '0;
         cmd_frame_o <= '0;
         rd_req_o    <= 1'b0;
         rd_addr_o   <= '0;
         sel_q       <= TX_ZERO;
         echo_q      <= '0;
      end else if (clr) begin
         en_q        <= 1'b0;
         cmd_valid_o <= 1'b0;
         rd_req_o    <= 1'b0;
         sel_q       <= TX_ZERO;
         echo_q      <= '0;
      end else begin
         cmd_valid_o <= 1'b0;
         rd_req_o    <= 1'b0;
         if (frame_done) begin
            if (kind != CMD_NONE) begin
               cmd_valid_o <= 1'b1;
               cmd_kind_o  <= kind;
               cmd_frame_o <= sh;
            end
            if (kind == CMD_ENABLE) en_q <= 1'b1;
         end
         if (byte_done) begin
            echo_q <= sh[BYTE_W-1:0];
            if (byte_idx == IDX_W'(FRAME_BYTES - 1)) begin
               sel_q <= TX_ZERO;
            end else if (byte_idx == IDX_W'(FRAME_BYTES - 2) && en_q &&
                         kind_of(mid_opc) == CMD_READ) begin
               sel_q     <= TX_RDATA;
               rd_req_o  <= 1'b1;
               rd_addr_o <= sh[ADDR_W-1:0];
            end else begin
               sel_q <= TX_ECHO;
            end
         end
      end
   end

   always_comb begin
      case (sel_q)
         TX_ECHO:  load_val = echo_q;
         TX_RDATA: load_val = rd_data_i;
         default:  load_val = '0;
      endcase
   end

   sprog_tx #(.BYTE_W(BYTE_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(clr), .fall(fall),
      .load_req(byte_done), .load_val(load_val), .miso_o(miso_o));

   // R6: nothing but an enable frame is passed on without the enable state
   p_cmd_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_kind_o != 3'(CMD_ENABLE)) |-> en_q);

   // R8: read requests come only from an enabled state
   p_rdreq_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> en_q);

   // R1: closed window keeps the command outputs quiet
   p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_i |=> (!cmd_valid_o && !rd_req_o && !en_q));

   // R7: a pulse never carries the empty kind
   p_kind_defined_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> (cmd_kind_o != 3'(CMD_NONE)));
endmodule

// File: tb/sprog_target_test.sv
`timescale 1ns/1ps
module sprog_target_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold_i = 1'b0;
   logic        sck_i = 1'b0;
   logic        mosi_i = 1'b0;
   logic        miso_o;
   logic        cmd_valid_o;
   logic [2:0]  cmd_kind_o;
   logic [31:0] cmd_frame_o;
   logic        rd_req_o;
   logic [15:0] rd_addr_o;
   logic [7:0]  rd_data_i;

   always #10 clk = ~clk;

   sprog_target uut (
      .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .sck_i(sck_i),
      .mosi_i(mosi_i), .miso_o(miso_o), .cmd_valid_o(cmd_valid_o),
      .cmd_kind_o(cmd_kind_o), .cmd_frame_o(cmd_frame_o),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i));

   // memory model: data is a fixed function of the address
   assign rd_data_i = rd_addr_o[7:0] ^ 8'h5A;

   int checks = 0;
   int errors = 0;
   int vcount = 0;
   int rcount = 0;
   logic [2:0]  last_kind;
   logic [31:0] last_frame;
   logic [15:0] last_addr;
   int stable_bad;
   bit done = 0;

   always @(posedge clk) begin
      if (cmd_valid_o) begin
         vcount++;
         last_kind  <= cmd_kind_o;
         last_frame <= cmd_frame_o;
      end
      if (rd_req_o) begin
         rcount++;
         last_addr <= rd_addr_o;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // clocks n bits MSB first, returning what came back on miso
   task automatic send_bits(input logic [31:0] val, input int n,
                            output logic [31:0] back);
      back = '0;
      for (int i = n - 1; i >= 0; i--) begin
         logic m1;
         mosi_i = val[i];
         #200;
         m1 = miso_o;
         back = {back[30:0], m1};
         sck_i = 1'b1;
         #200;
         if (miso_o !== m1) stable_bad++;
         sck_i = 1'b0;
      end
      #200;
   endtask

   task automatic frame(input logic [31:0] f, output logic [31:0] back);
      send_bits(f, 32, back);
   endtask

   // stimulus table: {frame, expect_pulse, expect_kind}
   localparam int NV = 8;
   localparam logic [35:0] VEC [NV] = '{
      {32'h40_00_05_11, 1'b0, 3'd0},   // load before enable: ignored (R6)
      {32'hAC_53_00_00, 1'b1, 3'd1},   // enable (R5)
      {32'h40_00_05_11, 1'b1, 3'd2},   // load (R7)
      {32'hC0_00_05_00, 1'b1, 3'd3},   // write (R7)
      {32'h20_01_23_00, 1'b1, 3'd4},   // read (R7, R8)
      {32'h80_00_00_00, 1'b0, 3'd0},   // pattern 100: no kind (R7)
      {32'hE0_11_22_33, 1'b0, 3'd0},   // pattern 111: no kind (R7)
      {32'h5F_12_34_56, 1'b1, 3'd2}    // load, upper range (R7, R2)
   };

   initial begin
      logic [31:0] back, exp_back;
      int v0, r0;
      stable_bad = 0;
      repeat (5) @(posedge clk);
      #5 rst_n = 1'b1;
      #100;
      chk(miso_o === 1'b0, "R1 miso after reset", {31'd0, miso_o}, 0);
      chk(vcount == 0 && rcount == 0, "R1 no pulses after reset", vcount, 0);
      hold_i = 1'b1;
      #200;

      for (int k = 0; k < NV; k++) begin
         logic [31:0] f;
         bit is_rd;
         f = VEC[k][35:4];
         v0 = vcount; r0 = rcount;
         frame(f, back);
         is_rd = VEC[k][3] && VEC[k][2:0] == 3'd4;
         exp_back = {8'h00, f[31:8]};
         if (is_rd) exp_back[7:0] = f[15:8] ^ 8'h5A;
         chk(back[15:8] == f[23:16], "R4 third byte echoes second", back[15:8], f[23:16]);
         chk(back[31:16] == exp_back[31:16], "R11 first/second byte echo",
             back[31:16], exp_back[31:16]);
         chk(back[7:0] == exp_back[7:0],
             is_rd ? "R8 read data in fourth byte" : "R11 R6 fourth byte echo",
             back[7:0], exp_back[7:0]);
         chk(vcount - v0 == int'(VEC[k][3]), "R6 R7 pulse count", vcount - v0, VEC[k][3]);
         if (VEC[k][3]) begin
            chk(last_kind == VEC[k][2:0], "R7 R5 kind", last_kind, VEC[k][2:0]);
            chk(last_frame == f, "R2 frame assembly", last_frame, f);
         end
         chk(rcount - r0 == int'(is_rd), "R8 R6 read request count", rcount - r0, is_rd);
         if (is_rd)
            chk(last_addr == f[23:8], "R8 read address", last_addr, f[23:8]);
      end
      chk(stable_bad == 0, "R3 miso stable while sck high", stable_bad, 0);

      // R10: partial frame then window close
      send_bits(32'h0000_40_00, 13, back);
      hold_i = 1'b0;
      #100;
      chk(miso_o === 1'b0, "R1 miso low with window closed", {31'd0, miso_o}, 0);
      #200;
      hold_i = 1'b1;
      #200;
      v0 = vcount;
      frame(32'h40_00_07_22, back);
      chk(vcount == v0, "R10 enable cleared by window close", vcount - v0, 0);

      // R9: wrong echo byte, still aligned afterwards
      v0 = vcount;
      frame(32'hAC_12_00_00, back);
      chk(vcount == v0, "R9 bad enable not accepted", vcount - v0, 0);
      chk(back[15:8] == 8'h12, "R9 R4 echo shows mismatch", back[15:8], 8'h12);
      frame(32'h40_00_08_33, back);
      chk(vcount == v0, "R9 R6 still disabled", vcount - v0, 0);
      frame(32'hAC_53_00_00, back);
      chk(vcount == v0 + 1 && last_kind == 3'd1, "R9 R10 aligned enable", last_kind, 1);
      chk(back[15:8] == 8'h53, "R4 enable echo 0x53", back[15:8], 8'h53);

      // R8: second read with other address
      r0 = rcount;
      frame(32'h28_AB_CD_00, back);
      chk(rcount == r0 + 1, "R8 read request", rcount - r0, 1);
      chk(last_addr == 16'hABCD, "R8 address", last_addr, 16'hABCD);
      chk(back[7:0] == 8'h97, "R8 read data", back[7:0], 8'h97);
      chk(stable_bad == 0, "R3 miso stable overall", stable_bad, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #3000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule